// File: doc/BRIEF.md
# Acquisition Card Register Interface

This block is the register front end of a multichannel data acquisition card. It sits on a simple local bus with a word-aligned byte address, separate read and write strobes and 16-bit data. Several offsets have one meaning for a write and another for a read. A write selects the input channel, sets the amplifier gain code, programs the interrupt-source and trigger-mode fields, or loads the 16-bit digital output latch. A read returns a status word, the 16 digital input pins, or the latest converter result tagged with its channel.

Two offsets act as commands rather than storage. A write to the trigger offset produces a one-cycle software trigger pulse for the trigger logic. A read of the same offset produces a one-cycle interrupt-clear pulse. The input-type strap decides how many channel bits are kept. The channel tag attached to a result is taken when the converter starts its conversion, so a channel change made while a conversion runs does not alter that result's tag. The timers, the trigger sequencing and the host bridge sit outside this block.

Top module: `acq_regif`

## Requirements
- R1: After reset, chan_sel, gain_sel, irq_src, trig_mode and dout are all 0, and sw_trig and irq_clr are low.
- R2: A write to offset 0x10 loads chan_sel. When se_strap is 1 (single-ended), wdata[4:0] is kept. When se_strap is 0 (differential), wdata[3:0] is kept and chan_sel[4] becomes 0.
- R3: A write to offset 0x14 loads gain_sel from wdata[1:0]. The other data bits are dropped.
- R4: A write to offset 0x18 loads irq_src from wdata[4:2] and trig_mode from wdata[1:0].
- R5: A write to offset 0x1C drives sw_trig high for exactly the one cycle after the write edge, whatever the data.
- R6: A read of offset 0x1C drives irq_clr high for exactly the one cycle after the read edge, and the read returns 0.
- R7: A write to offset 0x20 loads dout with wdata[15:0]. A read of offset 0x20 returns din.
- R8: A read of offset 0x10 returns a status word with these fields: bits 15:8 are 0, bits 7:6 are gain_sel, bit 5 is timer_out[1], bit 4 is timer_out[0], bit 3 is timer_out[2], bit 2 is 0, bit 1 is se_strap, and bit 0 is the inverse of conv_busy.
- R9: A read of offset 0x30 returns the channel tag in bits 15:12 and conv_data in bits 11:0. The tag is chan_sel[3:0] as sampled on the clock edge where conv_busy is first seen high. It is 0 until the first conversion starts.
- R10: A channel write made while conv_busy stays high does not change the tag returned at offset 0x30.
- R11: Reads of any offset other than 0x10, 0x20 and 0x30 return 0. Writes to any offset other than 0x10, 0x14, 0x18, 0x1C and 0x20 change no output and raise no strobe.
- R12: rdata is 0 in every cycle where rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 6 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle rd_en is high |
| conv_data | input | 12 | Latest converter sample |
| conv_busy | input | 1 | Converter busy, high while converting |
| timer_out | input | 3 | Outputs of the three timer channels |
| se_strap | input | 1 | Input type strap, 1 = single-ended |
| din | input | 16 | Digital input pins |
| dout | output | 16 | Digital output latch |
| chan_sel | output | 5 | Selected analog channel |
| gain_sel | output | 2 | Amplifier gain code |
| irq_src | output | 3 | Interrupt source select |
| trig_mode | output | 2 | Trigger mode select |
| sw_trig | output | 1 | One-cycle software trigger pulse |
| irq_clr | output | 1 | One-cycle interrupt clear pulse |

## Verification
The assertions check properties that hold on every cycle. Each command access must be followed by its strobe. Registers that are not addressed must hold their values. The differential write must leave channel bit 4 at zero. The inverted busy bit must appear in the status word. Unmapped reads and idle cycles must return zero. Field packing, the full strap masking and the tag capture at conversion start depend on values chosen by the stimulus, so only the bench's sweeps can show them. The bench sweeps all channel codes under both strap settings, all gain and control codes, every status input combination, and every address for both reads and writes. It also runs a conversion in which the channel is changed mid-flight.

// File: rtl/acq_regif_pkg.sv
// Package: shared widths, offsets and the control field type for acq_regif.
// Assumes a 6-bit byte address space with word-aligned registers.
package acq_regif_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int CHAN_W   = 5;
    localparam int TAG_W    = 4;
    localparam int GAIN_W   = 2;
    localparam int SAMPLE_W = 12;
    localparam int NTIMER   = 3;
    localparam int SRC_W    = 3;
    localparam int MODE_W   = 2;

    localparam logic [ADDR_W-1:0] OFS_CHAN = 6'h10; // write: channel, read: status
    localparam logic [ADDR_W-1:0] OFS_GAIN = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h1C; // write: trigger, read: irq clear
    localparam logic [ADDR_W-1:0] OFS_DIO  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_RES  = 6'h30;

    typedef struct packed {
        logic [SRC_W-1:0]  irq_src;
        logic [MODE_W-1:0] trig_mode;
    } ctrl_t;
endpackage

// File: rtl/acq_regif_wregs.sv
// Module: write-side register file (channel, gain, control, output latch).
// Assumes at most one write per cycle; the strap is sampled at write time.
module acq_regif_wregs
    import acq_regif_pkg::*;
#(
    parameter int CW = CHAN_W,
    parameter int GW = GAIN_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              se_strap,
    output logic [CW-1:0]     chan_sel,
    output logic [GW-1:0]     gain_sel,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     dout
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [CW-1:0] chan_masked;

    // Keep one channel bit fewer when the inputs are wired differentially.
    always_comb begin
        chan_masked = wdata[CW-1:0];
        if (!se_strap)
            chan_masked[CW-1] = 1'b0;
    end

    // Channel select register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_sel <= '0;
        else if (wr_en && addr == OFS_CHAN)
            chan_sel <= chan_masked;
    end

    // Gain code register, low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_sel <= '0;
        else if (wr_en && addr == OFS_GAIN)
            gain_sel <= wdata[GW-1:0];
    end

    // Interrupt source and trigger mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && addr == OFS_CTRL)
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Digital output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (wr_en && addr == OFS_DIO)
            dout <= wdata;
    end
endmodule

// File: rtl/acq_regif_tag.sv
// Module: captures the channel tag when a conversion starts.
// Assumes conv_busy is synchronous to clk and rises once per conversion.
module acq_regif_tag
    import acq_regif_pkg::*;
#(
    parameter int TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_busy,
    input  logic [TW-1:0] chan_lo,
    output logic [TW-1:0] tag
);
    logic busy_q;

    // Previous busy level, used for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= conv_busy;
    end

    // Take the channel on the first busy cycle of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag <= '0;
        else if (conv_busy && !busy_q)
            tag <= chan_lo;
    end
endmodule

// File: rtl/acq_regif_strobe.sv
// Module: registered one-cycle strobes, one per command hit.
// Assumes each hit input is high for a single cycle per access.
module acq_regif_strobe #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        // Delay the access hit by one register stage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pulse[i] <= 1'b0;
            else
                pulse[i] <= hit[i];
        end
    end
endmodule

// File: rtl/acq_regif_rdmux.sv
// Module: read data selection for status, digital inputs and results.
// Assumes rdata is sampled in the same cycle as rd_en; idle output is 0.
module acq_regif_rdmux
    import acq_regif_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int GW = GAIN_W,
    parameter int TW = TAG_W,
    parameter int SW = SAMPLE_W,
    parameter int NT = NTIMER
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GW-1:0]     gain_sel,
    input  logic [NT-1:0]     timer_out,
    input  logic              se_strap,
    input  logic              conv_busy,
    input  logic [DW-1:0]     din,
    input  logic [TW-1:0]     tag,
    input  logic [SW-1:0]     conv_data,
    output logic [DW-1:0]     rdata
);
    localparam int STAT_W = GW + NT + 3;

    logic [STAT_W-1:0] status;

    // Pack the status fields; timer 2 sits below timers 0 and 1.
    always_comb begin
        status = {gain_sel, timer_out[1], timer_out[0], timer_out[2],
                  1'b0, se_strap, ~conv_busy};
    end

    // Select the read source by offset.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_CHAN: rdata = DW'(status);
                OFS_DIO:  rdata = din;
                OFS_RES:  rdata = {tag, conv_data};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/acq_regif.sv
// Module: top of the acquisition card register interface.
// Assumes one bus access per cycle and synchronous inputs.
module acq_regif
    import acq_regif_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W,
    parameter int TW = TAG_W,
    parameter int GW = GAIN_W,
    parameter int SW = SAMPLE_W,
    parameter int NT = NTIMER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [SW-1:0]     conv_data,
    input  logic              conv_busy,
    input  logic [NT-1:0]     timer_out,
    input  logic              se_strap,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic [CW-1:0]     chan_sel,
    output logic [GW-1:0]     gain_sel,
    output logic [SRC_W-1:0]  irq_src,
    output logic [MODE_W-1:0] trig_mode,
    output logic              sw_trig,
    output logic              irq_clr
);
    ctrl_t         ctrl;
    logic [TW-1:0] tag;
    logic [1:0]    cmd_hit;
    logic [1:0]    cmd_pulse;

    acq_regif_wregs #(.CW(CW), .GW(GW), .DW(DW)) u_wregs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .se_strap(se_strap), .chan_sel(chan_sel), .gain_sel(gain_sel),
        .ctrl(ctrl), .dout(dout)
    );

    acq_regif_tag #(.TW(TW)) u_tag (
        .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy),
        .chan_lo(chan_sel[TW-1:0]), .tag(tag)
    );

    // Command hits: bit 0 trigger write, bit 1 clear read.
    always_comb begin
        cmd_hit[0] = wr_en && (addr == OFS_CMD);
        cmd_hit[1] = rd_en && (addr == OFS_CMD);
    end

    acq_regif_strobe #(.N(2)) u_strobe (
        .clk(clk), .rst_n(rst_n), .hit(cmd_hit), .pulse(cmd_pulse)
    );

    acq_regif_rdmux #(.DW(DW), .GW(GW), .TW(TW), .SW(SW), .NT(NT)) u_rdmux (
        .rd_en(rd_en), .addr(addr), .gain_sel(gain_sel), .timer_out(timer_out),
        .se_strap(se_strap), .conv_busy(conv_busy), .din(din), .tag(tag),
        .conv_data(conv_data), .rdata(rdata)
    );

    // Route the control fields and strobes to the ports.
    always_comb begin
        irq_src   = ctrl.irq_src;
        trig_mode = ctrl.trig_mode;
        sw_trig   = cmd_pulse[0];
        irq_clr   = cmd_pulse[1];
    end
endmodule

// File: rtl/acq_regif_chk.sv
// Module: assertion checker bound to acq_regif.
// Assumes the port names of acq_regif; every property is disabled in reset.
module acq_regif_chk
    import acq_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              conv_busy,
    input logic              se_strap,
    input logic [DATA_W-1:0] dout,
    input logic [CHAN_W-1:0] chan_sel,
    input logic [GAIN_W-1:0] gain_sel,
    input logic              sw_trig,
    input logic              irq_clr
);
    logic rd_mapped;
    always_comb rd_mapped = (addr == OFS_CHAN) || (addr == OFS_DIO) || (addr == OFS_RES);

    a_r5_trig_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CMD) |=> sw_trig);
    a_r5_trig_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_CMD) |=> !sw_trig);
    a_r6_clr_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CMD) |=> irq_clr);
    a_r6_clr_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == OFS_CMD) |=> !irq_clr);
    a_r2_diff_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CHAN && !se_strap) |=> (chan_sel[CHAN_W-1] == 1'b0));
    a_r2_chan_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_CHAN) |=> $stable(chan_sel));
    a_r3_gain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_GAIN) |=> $stable(gain_sel));
    a_r7_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_DIO) |=> $stable(dout));
    a_r8_busy_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CHAN) |-> (rdata[0] == !conv_busy));
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_mapped) |-> (rdata == '0));
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

bind acq_regif acq_regif_chk u_chk (.*);

// File: tb/acq_regif_test.sv
`timescale 1ns/1ps
module acq_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [11:0] conv_data = '0;
    logic        conv_busy = 1'b0;
    logic [2:0]  timer_out = '0;
    logic        se_strap = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [4:0]  chan_sel;
    logic [1:0]  gain_sel;
    logic [2:0]  irq_src;
    logic [1:0]  trig_mode;
    logic        sw_trig, irq_clr;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    acq_regif uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [31:0] outs();
        return {dout, chan_sel, gain_sel, irq_src, trig_mode, sw_trig, irq_clr};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", outs(), 32'h0);
        // R12 idle read data
        chk("R12", {16'h0, rdata}, 32'h0);

        // R2 channel masking under both strap values
        for (int s = 0; s < 2; s++) begin
            se_strap = s[0];
            for (int v = 0; v < 64; v++) begin
                wr(6'h10, 16'(v) | 16'hFFC0);
                chk("R2", {27'h0, chan_sel}, 32'(v & (s == 1 ? 31 : 15)));
            end
        end
        se_strap = 1'b1;

        // R3 gain code and its status field
        for (int v = 0; v < 8; v++) begin
            wr(6'h14, 16'(v) | 16'hAB00);
            chk("R3", {30'h0, gain_sel}, 32'(v % 4));
            rd(6'h10, d);
            chk("R3 status", {30'h0, d[7:6]}, 32'(v % 4));
        end

        // R4 control fields
        for (int v = 0; v < 64; v++) begin
            wr(6'h18, 16'(v));
            chk("R4 src", {29'h0, irq_src}, 32'((v / 4) % 8));
            chk("R4 mode", {30'h0, trig_mode}, 32'(v % 4));
        end

        // R5 trigger pulse: high one cycle, independent of data
        wr(6'h1C, 16'h0000);
        chk("R5 high", {31'h0, sw_trig}, 32'h1);
        @(negedge clk);
        chk("R5 low", {31'h0, sw_trig}, 32'h0);
        wr(6'h1C, 16'hFFFF);
        chk("R5 high", {31'h0, sw_trig}, 32'h1);
        @(negedge clk);
        chk("R5 low", {31'h0, sw_trig}, 32'h0);

        // R6 clear pulse on read
        rd(6'h1C, d);
        chk("R6 data", {16'h0, d}, 32'h0);
        chk("R6 high", {31'h0, irq_clr}, 32'h1);
        @(negedge clk);
        chk("R6 low", {31'h0, irq_clr}, 32'h0);

        // R7 output latch and input pins
        for (int i = 0; i < 16; i++) begin
            wr(6'h20, 16'h1 << i);
            chk("R7 dout", {16'h0, dout}, 32'h1 << i);
            din = ~(16'h1 << i);
            rd(6'h20, d);
            chk("R7 din", {16'h0, d}, {16'h0, ~(16'h1 << i)});
        end
        wr(6'h20, 16'hA5C3);
        chk("R7 dout", {16'h0, dout}, 32'hA5C3);

        // R8 status layout across timers, busy and strap
        wr(6'h14, 16'h2);
        for (int t = 0; t < 8; t++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 2; s++) begin
                    timer_out = 3'(t); conv_busy = b[0]; se_strap = s[0];
                    rd(6'h10, d);
                    chk("R8", {16'h0, d},
                        32'(2 * 64 + ((t >> 1) & 1) * 32 + (t & 1) * 16 +
                            ((t >> 2) & 1) * 8 + s * 2 + (1 - b)));
                end
        conv_busy = 1'b0; se_strap = 1'b1; timer_out = '0;
        @(negedge clk);

        // R9 tag capture at conversion start
        wr(6'h10, 16'd27);
        conv_data = 12'h5A7;
        @(negedge clk); conv_busy = 1'b1;
        @(negedge clk);
        rd(6'h30, d);
        chk("R9", {16'h0, d}, 32'hB5A7);
        // R10 channel change during conversion
        wr(6'h10, 16'd4);
        conv_data = 12'h0F1;
        rd(6'h30, d);
        chk("R10", {16'h0, d}, 32'hB0F1);
        @(negedge clk); conv_busy = 1'b0;
        @(negedge clk); conv_busy = 1'b1;
        @(negedge clk);
        rd(6'h30, d);
        chk("R9 next", {16'h0, d}, 32'h40F1);
        conv_busy = 1'b0;

        // R11 reads at every offset
        din = 16'h3C3C;
        for (int a = 0; a < 64; a++) begin
            if (a != 16 && a != 32 && a != 48) begin
                rd(6'(a), d);
                chk("R11 read", {16'h0, d}, 32'h0);
            end
        end
        // R11 writes to every offset outside the write map
        for (int a = 0; a < 64; a++) begin
            if (a != 16 && a != 20 && a != 24 && a != 28 && a != 32) begin
                @(negedge clk);
                snap = outs();
                wr(6'(a), 16'hFFFF);
                chk("R11 write", outs(), snap);
            end
        end
        // R12 idle read data after activity
        @(negedge clk); addr = 6'h20;
        #1 chk("R12", {16'h0, rdata}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule